// File: doc/BRIEF.md
# Two-Pin PWM Timer with Split Counter Mode

This block is a compare-mode timer that produces pulse-width modulated waveforms on two output pins. Its counter either runs as one full-width counter or splits into two independent half-width counters (an upper half and a lower half), and each half has its own run control. Every counter counts up from its reload value. The waveform leaves its starting level when the count matches the compare value. It returns to the starting level when the counter wraps and reloads.

A two-bit output enable chooses, separately for each pin, between the timer waveform and a plain port-latch bit. A polarity input sets the starting level of a pin's waveform, and it is sampled only when that pin's enable bit turns on.

A one-shot request produces exactly one waveform period and then halts the counter. In full-width mode the one-shot can be held back by a gate input. Each counter raises a sticky wrap flag.

Top module: `pwm2_gen`

## Requirements
- R1: When an output-enable bit is 0 the matching pin equals its port-latch input (bit 0 controls `pin_a` with `latch_a`, bit 1 controls `pin_b` with `latch_b`), whatever the mode.
- R2: With `split` = 0 the full-width waveform drives `pin_a` when `oe[0]` = 1 and drives `pin_b` when `oe[1]` = 1, so `oe` = 11 gives the same waveform on both pins.
- R3: With `split` = 1, `pin_a` carries the upper-half counter's waveform and `pin_b` carries the lower-half counter's waveform. The upper half uses the upper halves of `reload` and `cmp`, and the lower half uses the lower halves.
- R4: On every enabled cycle a counter at its all-ones value loads `reload`; otherwise it increments. Its waveform moves away from the starting level in the cycle after the count equals `cmp`, and returns to the starting level in the cycle after the wrap.
- R5: Each pin latches `pol` (0 = starts low, 1 = starts high) only in the cycle its enable bit goes from 0 to 1. Later changes of `pol` leave the pin unchanged.
- R6: `run_hi` runs the full counter (`split` = 0) or the upper half (`split` = 1). `run_lo` runs only the lower half and has no effect when `split` = 0. A counter that is not running holds its count.
- R7: `ovf_hi` sets on a wrap of the full or upper counter, and `ovf_lo` sets on a wrap of the lower counter. Each flag stays set until a pulse on `ovf_clr[1]` or `ovf_clr[0]` respectively clears it, and a wrap in the same cycle as the clear wins.
- R8: A pulse on `oneshot` loads `reload` into the full or upper counter and clears its waveform. The counter arms for one cycle, then runs (whatever `run_hi` is) up to and including the wrap, and then holds unless `run_hi` = 1.
- R9: With `split` = 0 and `gate_en` = 1, an armed one-shot stays armed while `gate_in` = 1 and starts on the first cycle `gate_in` = 0. With `split` = 1 the gate is ignored.
- R10: After reset the counters are 0, both flags are 0, and both pins show the port-latch inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split | input | 1 | 1 = two half-width counters |
| run_hi | input | 1 | Run full / upper counter |
| run_lo | input | 1 | Run lower counter (split mode only) |
| oneshot | input | 1 | One-cycle pulse starting a single period |
| pol | input | 1 | Starting level, sampled on enable turn-on |
| oe | input | 2 | Per-pin waveform enable |
| reload | input | CW | Reload value(s) |
| cmp | input | CW | Compare value(s) |
| gate_en | input | 1 | Gate the one-shot start |
| gate_in | input | 1 | Gate level, 1 holds the one-shot |
| latch_a | input | 1 | Port-latch value for pin A |
| latch_b | input | 1 | Port-latch value for pin B |
| ovf_clr | input | 2 | Flag clear pulses (1 = upper/full, 0 = lower) |
| pin_a | output | 1 | Pin A |
| pin_b | output | 1 | Pin B |
| ovf_hi | output | 1 | Full/upper wrap flag |
| ovf_lo | output | 1 | Lower wrap flag |

## Verification
A behavioural reference model is compared with all four outputs on every cycle. The full-width counter is driven under each enable pattern, both polarities and a mid-run polarity change, which separates pin routing from polarity latching. Split mode is run with both halves running, then with only the lower half, which shows that the two counters are independent. One-shots are started free, gated and in split mode with the gate asserted. Measured high-time counts then separate a single period from free running, and a held gate from a late start.

// File: rtl/pwm2_gen.sv
module pwm2_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          split,
  input  logic          run_hi,
  input  logic          run_lo,
  input  logic          oneshot,
  input  logic          pol,
  input  logic [1:0]    oe,
  input  logic [CW-1:0] reload,
  input  logic [CW-1:0] cmp,
  input  logic          gate_en,
  input  logic          gate_in,
  input  logic          latch_a,
  input  logic          latch_b,
  input  logic [1:0]    ovf_clr,
  output logic          pin_a,
  output logic          pin_b,
  output logic          ovf_hi,
  output logic          ovf_lo
);
  localparam int HW = CW / 2;

  typedef enum logic [1:0] {SS_IDLE, SS_ARM, SS_RUN} ss_t;

  logic [CW-1:0] cnt;
  logic          t_hi, t_lo;
  ss_t           ss;
  logic [1:0]    oe_q;
  logic          pol_a_q, pol_b_q;

  wire [HW-1:0] hi_cnt = cnt[CW-1:HW];
  wire [HW-1:0] lo_cnt = cnt[HW-1:0];

  wire gated    = gate_en & ~split & gate_in;
  wire hi_en    = (ss == SS_RUN) | (run_hi & (ss == SS_IDLE));
  wire lo_en    = split & run_lo;
  wire full_top = &cnt;
  wire hi_top   = &hi_cnt;
  wire lo_top   = &lo_cnt;
  wire hi_wrap  = hi_en & (split ? hi_top : full_top);
  wire lo_wrap  = lo_en & lo_top;
  wire hi_match = split ? (hi_cnt == cmp[CW-1:HW]) : (cnt == cmp);
  wire lo_match = lo_cnt == cmp[HW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!split) begin
      if (oneshot)    cnt <= reload;
      else if (hi_en) cnt <= full_top ? reload : cnt + 1'b1;
    end else begin
      if (oneshot)    cnt[CW-1:HW] <= reload[CW-1:HW];
      else if (hi_en) cnt[CW-1:HW] <= hi_top ? reload[CW-1:HW] : hi_cnt + 1'b1;
      if (lo_en)      cnt[HW-1:0]  <= lo_top ? reload[HW-1:0] : lo_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_hi <= 1'b0;
      t_lo <= 1'b0;
      ss   <= SS_IDLE;
    end else begin
      if (oneshot || hi_wrap)  t_hi <= 1'b0;
      else if (hi_en && hi_match) t_hi <= 1'b1;
      if (lo_wrap)             t_lo <= 1'b0;
      else if (lo_en && lo_match) t_lo <= 1'b1;
      if (oneshot)                       ss <= SS_ARM;
      else if (ss == SS_ARM && !gated)   ss <= SS_RUN;
      else if (ss == SS_RUN && hi_wrap)  ss <= SS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_hi <= 1'b0;
      ovf_lo <= 1'b0;
    end else begin
      if (hi_wrap)         ovf_hi <= 1'b1;
      else if (ovf_clr[1]) ovf_hi <= 1'b0;
      if (lo_wrap)         ovf_lo <= 1'b1;
      else if (ovf_clr[0]) ovf_lo <= 1'b0;
    end
  end

  wire rise_a = oe[0] & ~oe_q[0];
  wire rise_b = oe[1] & ~oe_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q    <= 2'b00;
      pol_a_q <= 1'b0;
      pol_b_q <= 1'b0;
    end else begin
      oe_q <= oe;
      if (rise_a) pol_a_q <= pol;
      if (rise_b) pol_b_q <= pol;
    end
  end

  wire start_a = rise_a ? pol : pol_a_q;
  wire start_b = rise_b ? pol : pol_b_q;

  assign pin_a = oe[0] ? (start_a ^ t_hi) : latch_a;
  assign pin_b = oe[1] ? (start_b ^ (split ? t_lo : t_hi)) : latch_b;

  a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && hi_en && full_top && !oneshot) |=> cnt == $past(reload));
  a_r6_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && !ovf_lo) |=> !ovf_lo);
  a_r7_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hi && !ovf_clr[1]) |=> ovf_hi);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ss == SS_IDLE && !run_hi && !oneshot && !split) |=> $stable(cnt));
  a_r9_gate_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (ss == SS_ARM && gated && !oneshot) |=> ss == SS_ARM);
endmodule

// File: tb/pwm2_gen_test.sv
`timescale 1ns/1ps
module pwm2_gen_test;
  logic clk = 0, rst_n = 0;
  logic split = 0, run_hi = 0, run_lo = 0, oneshot = 0, pol = 0;
  logic [1:0] oe = 0, ovf_clr = 0;
  logic [15:0] reload = 0, cmp = 0;
  logic gate_en = 0, gate_in = 0, latch_a = 1, latch_b = 0;
  logic pin_a, pin_b, ovf_hi, ovf_lo;
  int checks = 0, fails = 0;
  string tag = "R10";
  bit done = 0;

  always #4 clk = ~clk;

  pwm2_gen #(.CW(16)) uut (.clk, .rst_n, .split, .run_hi, .run_lo, .oneshot, .pol, .oe,
    .reload, .cmp, .gate_en, .gate_in, .latch_a, .latch_b, .ovf_clr,
    .pin_a, .pin_b, .ovf_hi, .ovf_lo);

  // behavioural reference
  logic [15:0] mc;
  bit mth, mtl, moh, mol, mpa, mpb;
  logic [1:0] moep;
  int mss;

  task automatic chk(string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %b expected %b", tag, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = 0; mth = 0; mtl = 0; moh = 0; mol = 0; mpa = 0; mpb = 0; moep = 0; mss = 0;
    end else begin
      int h, l;
      bit en, go;
      if (oe[0] && !moep[0]) mpa = pol;
      if (oe[1] && !moep[1]) mpb = pol;
      moep = oe;
      if (ovf_clr[1]) moh = 0;
      if (ovf_clr[0]) mol = 0;
      h = mc[15:8]; l = mc[7:0];
      go = 0;
      if (oneshot) begin
        mth = 0; mss = 1;
        if (split) h = reload[15:8]; else mc = reload;
      end else if (mss == 1) begin
        if (split || !(gate_en && gate_in)) mss = 2;
      end else go = (mss == 2) || run_hi;
      if (!split) begin
        if (go) begin
          if (mc == 16'hFFFF) begin mc = reload; mth = 0; moh = 1; if (mss == 2) mss = 0; end
          else begin if (mc == cmp) mth = 1; mc = mc + 1; end
        end
      end else begin
        if (go) begin
          if (h == 255) begin h = reload[15:8]; mth = 0; moh = 1; if (mss == 2) mss = 0; end
          else begin if (h == cmp[15:8]) mth = 1; h++; end
        end
        if (run_lo) begin
          if (l == 255) begin l = reload[7:0]; mtl = 0; mol = 1; end
          else begin if (l == cmp[7:0]) mtl = 1; l++; end
        end
        mc = {h[7:0], l[7:0]};
      end
    end
    #2;
    if (rst_n && !done) begin
      chk("pin_a", pin_a, oe[0] ? (mpa ^ mth) : latch_a);
      chk("pin_b", pin_b, oe[1] ? (mpb ^ (split ? mtl : mth)) : latch_b);
      chk("ovf_hi", ovf_hi, moh);
      chk("ovf_lo", ovf_lo, mol);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge clk); if (pin_a) hi++; end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int hi;
    cyc(3);
    rst_n = 1;
    cyc(1);
    tag = "R10";
    chk("pin_a reset", pin_a, 1'b1);
    chk("pin_b reset", pin_b, 1'b0);
    chk("ovf_hi reset", ovf_hi, 1'b0);
    chk("ovf_lo reset", ovf_lo, 1'b0);

    tag = "R1"; reload = 16'hFFF0; cmp = 16'hFFF8; run_hi = 1;
    repeat (6) begin latch_a = ~latch_a; latch_b = ~latch_a; cyc(3); end
    split = 1; run_lo = 1; cyc(10); split = 0; run_lo = 0;

    tag = "R2"; oe = 2'b01; cyc(40);
    oe = 2'b10; cyc(40);
    oe = 2'b11; cyc(40);
    tag = "R4"; reload = 16'hFFE0; cmp = 16'hFFF0; cyc(80);
    tag = "R5"; pol = 1; cyc(40);
    oe = 2'b00; cyc(2); oe = 2'b11; cyc(40);
    oe = 2'b10; pol = 0; cyc(2); oe = 2'b11; cyc(40);
    tag = "R7"; ovf_clr = 2'b10; cyc(1); ovf_clr = 0; cyc(40);
    ovf_clr = 2'b10; cyc(5); ovf_clr = 0;
    tag = "R6"; run_hi = 0; run_lo = 1; cyc(30); run_lo = 0;

    tag = "R3"; split = 1; run_hi = 1; run_lo = 1; reload = 16'hF0E8; cmp = 16'hF6F0;
    oe = 2'b00; cyc(1); pol = 0; oe = 2'b11; cyc(120);
    ovf_clr = 2'b11; cyc(1); ovf_clr = 0;
    run_hi = 0; cyc(60); run_hi = 1; run_lo = 0; cyc(60);

    tag = "R8"; split = 0; run_hi = 0; run_lo = 0; reload = 16'hFFF0; cmp = 16'hFFF8;
    oe = 2'b00; cyc(1); oe = 2'b01; pol = 0; ovf_clr = 2'b10; cyc(1); ovf_clr = 0;
    oneshot = 1; cyc(1); oneshot = 0;
    count_high(60, hi);
    chk("one-shot high cycles (R8)", hi == 7, 1'b1);
    chk("one-shot wrap flag (R8)", ovf_hi, 1'b1);
    count_high(20, hi);
    chk("halted after one-shot (R8)", hi == 0, 1'b1);

    tag = "R9"; gate_en = 1; gate_in = 1; oneshot = 1; cyc(1); oneshot = 0;
    count_high(40, hi);
    chk("gated one-shot held (R9)", hi == 0, 1'b1);
    gate_in = 0;
    count_high(40, hi);
    chk("gate release starts period (R9)", hi == 7, 1'b1);
    split = 1; gate_in = 1; reload = 16'hF000; cmp = 16'hF600;
    oneshot = 1; cyc(1); oneshot = 0;
    count_high(40, hi);
    chk("split one-shot ignores gate (R9)", hi == 9, 1'b1);
    cyc(5);
    finish_run();
  end
endmodule